// File: doc/BRIEF.md
# Ethernet Pause Quanta Transmit Gate

This block sits between a transmit client and an Ethernet transmit MAC datapath. It takes pause events that the receive side has already decoded. Each event carries a 16-bit quanta value, an eight-bit class vector, an address-hit flag and a kind: standard or per-priority. The block checks each event against its configuration inputs. It then loads a countdown timer measured in pause quanta. One quantum is 512 bit times, so it lasts 512 / `DATA_W` clock cycles.

In standard mode a running standard timer closes the client interface, but only at a frame boundary. A frame already in progress completes. After its end-of-packet beat is accepted, `cli_ready` and `mac_valid` stay low until the timer expires or a zero-quanta event arrives.

In priority mode each class has its own timer. The block raises that class's bit on `class_paused` and never gates the datapath; the client does the throttling.

A newly accepted quanta value always replaces the running count and restarts the partial quantum.

Top module: `pause_tx_gate`

## Requirements
- R1: A standard pause of Q quanta, loaded with no frame open, keeps `cli_ready` low for exactly Q × (512 / DATA_W) clock cycles; with DATA_W = 256 that is 2·Q cycles.
- R2: In standard mode (`cfg_prio_mode` = 0) an event with `evt_kind` = 0 loads the standard timer only when all of these are 1: `cfg_rx_pause_en[0]`, `cfg_std_xoff_en` and `evt_addr_hit`. If any of them is 0, the event has no effect.
- R3: In priority mode (`cfg_prio_mode` = 1) an event with `evt_kind` = 1 and `evt_addr_hit` = 1 loads the timer of class i only when both `evt_class_vec[i]` and `cfg_rx_pause_en[i]` are 1.
- R4: A pause accepted while a frame is open (after an accepted beat with `cli_sop` = 1 and before its accepted `cli_eop` beat) does not lower `cli_ready` until that end-of-packet beat has been accepted.
- R5: In standard mode, while the standard timer is nonzero and no frame is open, `cli_ready` and `mac_valid` are both 0, so no new frame starts.
- R6: Each accepted quanta value overwrites the running count and is never added to it. This holds whether the new value is larger or smaller, and the last value received decides.
- R7: An accepted event with zero quanta clears its timer in the next cycle and releases the gate, or the class bit, at once.
- R8: In priority mode `class_paused[i]` is 1 exactly while the timer of class i is running. Classes expire independently, and `cli_ready` always equals `mac_ready`.
- R9: Loading a timer restarts its partial-quantum cycle counter, so a reload in the middle of a quantum lasts the full new length.
- R10: After reset no timer runs: `class_paused` is 0 and `cli_ready` equals `mac_ready`.
- R11: An event whose kind does not match the current mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_prio_mode | input | 1 | 0 = standard pause, 1 = per-priority pause |
| cfg_rx_pause_en | input | NUM_CLS | Receive pause enable per class; bit 0 also serves standard mode |
| cfg_std_xoff_en | input | 1 | Standard-mode XOFF enable |
| evt_valid | input | 1 | One-cycle strobe of a decoded pause event |
| evt_kind | input | 1 | 0 = standard event, 1 = priority event |
| evt_addr_hit | input | 1 | Destination address matched |
| evt_quanta | input | QUANTA_W | Pause length in quanta; 0 releases |
| evt_class_vec | input | NUM_CLS | Classes addressed by a priority event |
| cli_valid | input | 1 | Client beat valid |
| cli_data | input | DATA_W | Client beat data |
| cli_sop | input | 1 | Client start of packet |
| cli_eop | input | 1 | Client end of packet |
| cli_ready | output | 1 | Ready back to the client |
| mac_valid | output | 1 | Beat valid toward the MAC |
| mac_data | output | DATA_W | Beat data toward the MAC |
| mac_sop | output | 1 | Start of packet toward the MAC |
| mac_eop | output | 1 | End of packet toward the MAC |
| mac_ready | input | 1 | MAC ready |
| class_paused | output | NUM_CLS | Per-class paused status, used in priority mode |

## Verification
The bench targets these corner cases:
- **Pause arriving mid-frame.** A gate that engages at once would drop `cli_ready` on the middle or end beat of a frame and cut the frame short.
- **Reload with a larger and a smaller value.** A timer that accumulates instead of overwriting would hold the gate too long.
- **Reload in the middle of a quantum.** A timer that keeps its partial-quantum count would release a cycle early.
- **Zero-quanta event.** A design that only counts down would stay closed instead of reopening in the next cycle.
- **Each qualifying input held at 0, and an event of the wrong kind.** A design that misses one of these would close the gate when it should stay open.
- **Priority mode with staggered classes and a masked class.** A design that shares one timer between classes would release them together. One that ignores the per-class enable would raise a bit it should leave low. One that gates the datapath in this mode would stall the client.

// File: rtl/pqg_pkg.sv
// Package: shared types and derived constants for the pause transmit gate.
// Assumes DATA_W divides 512 (256 or 512 bits in practice).
package pqg_pkg;

    typedef enum logic {
        EVT_STD  = 1'b0,
        EVT_PRIO = 1'b1
    } evt_kind_e;

    // Cycles that one 512-bit-time pause quantum spans for a datapath width.
    function automatic int unsigned cycles_per_quantum(input int unsigned data_w);
        return 512 / data_w;
    endfunction

endpackage

// File: rtl/pqg_event_qual.sv
// Module: pqg_event_qual
// Turns a decoded pause event into load strobes: one for the standard timer
// and one per class timer. Assumes evt_valid is a single-cycle strobe.
// A strobe fires only when the event kind matches the mode and every enable
// condition for that mode holds.
module pqg_event_qual
    import pqg_pkg::*;
#(
    parameter int unsigned NUM_CLS = 8
) (
    input  logic               prio_mode,
    input  logic [NUM_CLS-1:0] rx_pause_en,
    input  logic               std_xoff_en,
    input  logic               evt_valid,
    input  logic               evt_kind,
    input  logic               evt_addr_hit,
    input  logic [NUM_CLS-1:0] evt_class_vec,
    output logic               std_load,
    output logic [NUM_CLS-1:0] cls_load
);

    logic base_ok;
    logic std_ok;
    logic prio_ok;

    // Conditions common to every mode, then the per-mode gating.
    always_comb begin
        base_ok = evt_valid && evt_addr_hit;
        std_ok  = base_ok && !prio_mode && (evt_kind == EVT_STD)
                  && std_xoff_en && rx_pause_en[0];
        prio_ok = base_ok && prio_mode && (evt_kind == EVT_PRIO);
    end

    assign std_load = std_ok;

    // One load strobe per class, masked by the class vector and its enable.
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        assign cls_load[c] = prio_ok && evt_class_vec[c] && rx_pause_en[c];
    end

endmodule

// File: rtl/pqg_quanta_timer.sv
// Module: pqg_quanta_timer
// Pause countdown in whole quanta, with a partial-quantum cycle counter.
// A load always replaces the count and restarts the partial quantum; a load of
// zero stops the timer immediately. busy is high while the count is nonzero.
module pqg_quanta_timer #(
    parameter int unsigned QUANTA_W = 16,
    parameter int unsigned CPQ      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [QUANTA_W-1:0] load_val,
    output logic [QUANTA_W-1:0] count,
    output logic                busy
);

    localparam int unsigned SUB_W = (CPQ > 1) ? $clog2(CPQ) : 1;
    localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(CPQ - 1);

    logic [SUB_W-1:0] sub_q;

    // Load overrides; otherwise step the partial quantum and count down.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count <= '0;
            sub_q <= '0;
        end else if (load) begin
            count <= load_val;
            sub_q <= '0;
        end else if (count != '0) begin
            if (sub_q == SUB_LAST) begin
                sub_q <= '0;
                count <= count - 1'b1;
            end else begin
                sub_q <= sub_q + 1'b1;
            end
        end
    end

    assign busy = (count != '0);

endmodule

// File: rtl/pqg_frame_gate.sv
// Module: pqg_frame_gate
// Passes client beats to the MAC and tracks whether a frame is open.
// hold_req closes the interface only when no frame is open, so a frame that
// has started always completes. Assumes the client marks frame beats with
// sop and eop.
module pqg_frame_gate #(
    parameter int unsigned DATA_W = 256
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hold_req,
    input  logic              cli_valid,
    input  logic [DATA_W-1:0] cli_data,
    input  logic              cli_sop,
    input  logic              cli_eop,
    output logic              cli_ready,
    output logic              mac_valid,
    output logic [DATA_W-1:0] mac_data,
    output logic              mac_sop,
    output logic              mac_eop,
    input  logic              mac_ready,
    output logic              in_frame
);

    logic hold;
    logic accept;

    // Gate only at a frame boundary.
    always_comb begin
        hold      = hold_req && !in_frame;
        cli_ready = mac_ready && !hold;
        mac_valid = cli_valid && !hold;
        accept    = cli_valid && cli_ready;
    end

    assign mac_data = cli_data;
    assign mac_sop  = cli_sop;
    assign mac_eop  = cli_eop;

    // Open on an accepted sop, close on an accepted eop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_frame <= 1'b0;
        end else if (accept) begin
            if (cli_eop) begin
                in_frame <= 1'b0;
            end else if (cli_sop) begin
                in_frame <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pause_tx_gate.sv
// Module: pause_tx_gate (top)
// Applies received pause events to the transmit side. Standard mode closes the
// client interface at frame boundaries while the standard timer runs. Priority
// mode reports per-class paused status and leaves the datapath open.
// Assumes DATA_W is 256 or 512, so one quantum spans 2 or 1 cycles.
module pause_tx_gate
    import pqg_pkg::*;
#(
    parameter int unsigned DATA_W   = 256,
    parameter int unsigned QUANTA_W = 16,
    parameter int unsigned NUM_CLS  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_prio_mode,
    input  logic [NUM_CLS-1:0]  cfg_rx_pause_en,
    input  logic                cfg_std_xoff_en,
    input  logic                evt_valid,
    input  logic                evt_kind,
    input  logic                evt_addr_hit,
    input  logic [QUANTA_W-1:0] evt_quanta,
    input  logic [NUM_CLS-1:0]  evt_class_vec,
    input  logic                cli_valid,
    input  logic [DATA_W-1:0]   cli_data,
    input  logic                cli_sop,
    input  logic                cli_eop,
    output logic                cli_ready,
    output logic                mac_valid,
    output logic [DATA_W-1:0]   mac_data,
    output logic                mac_sop,
    output logic                mac_eop,
    input  logic                mac_ready,
    output logic [NUM_CLS-1:0]  class_paused
);

    localparam int unsigned CPQ = cycles_per_quantum(DATA_W);

    logic                std_load;
    logic [NUM_CLS-1:0]  cls_load;
    logic [QUANTA_W-1:0] std_count;
    logic                std_busy;
    logic [NUM_CLS-1:0]  cls_busy;
    logic                hold_req;
    logic                in_frame;

    // Event qualification against mode and enables.
    pqg_event_qual #(.NUM_CLS(NUM_CLS)) u_qual (
        .prio_mode     (cfg_prio_mode),
        .rx_pause_en   (cfg_rx_pause_en),
        .std_xoff_en   (cfg_std_xoff_en),
        .evt_valid     (evt_valid),
        .evt_kind      (evt_kind),
        .evt_addr_hit  (evt_addr_hit),
        .evt_class_vec (evt_class_vec),
        .std_load      (std_load),
        .cls_load      (cls_load)
    );

    // Standard pause timer.
    pqg_quanta_timer #(.QUANTA_W(QUANTA_W), .CPQ(CPQ)) u_std_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (std_load),
        .load_val (evt_quanta),
        .count    (std_count),
        .busy     (std_busy)
    );

    // One timer per priority class.
    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls_tmr
        logic [QUANTA_W-1:0] cnt_unused;
        pqg_quanta_timer #(.QUANTA_W(QUANTA_W), .CPQ(CPQ)) u_tmr (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (cls_load[c]),
            .load_val (evt_quanta),
            .count    (cnt_unused),
            .busy     (cls_busy[c])
        );
    end

    // Gate request only in standard mode; status only in priority mode.
    always_comb begin
        hold_req     = std_busy && !cfg_prio_mode;
        class_paused = cfg_prio_mode ? cls_busy : '0;
    end

    // Frame-boundary gate on the client-to-MAC path.
    pqg_frame_gate #(.DATA_W(DATA_W)) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .hold_req  (hold_req),
        .cli_valid (cli_valid),
        .cli_data  (cli_data),
        .cli_sop   (cli_sop),
        .cli_eop   (cli_eop),
        .cli_ready (cli_ready),
        .mac_valid (mac_valid),
        .mac_data  (mac_data),
        .mac_sop   (mac_sop),
        .mac_eop   (mac_eop),
        .mac_ready (mac_ready),
        .in_frame  (in_frame)
    );

endmodule

// File: rtl/pqg_checker.sv
// Module: pqg_checker
// Temporal properties of pause_tx_gate; attached through the bind below.
module pqg_checker #(
    parameter int unsigned QUANTA_W = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                cfg_prio_mode,
    input logic                cfg_std_xoff_en,
    input logic                evt_addr_hit,
    input logic                std_load,
    input logic [QUANTA_W-1:0] evt_quanta,
    input logic [QUANTA_W-1:0] std_count,
    input logic                in_frame,
    input logic                cli_ready,
    input logic                mac_ready,
    input logic                mac_valid
);

    p_gate_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_prio_mode && std_count != '0 && !in_frame) |-> (!cli_ready && !mac_valid));

    p_frame_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        in_frame |-> (cli_ready == mac_ready));

    p_overwrite_r6: assert property (@(posedge clk) disable iff (!rst_n)
        std_load |=> (std_count == $past(evt_quanta)));

    p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (std_load && evt_quanta == '0) |=> (std_count == '0));

    p_prio_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_prio_mode |-> (cli_ready == mac_ready));

    p_disabled_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((!cfg_std_xoff_en || !evt_addr_hit) && std_count == '0) |=> (std_count == '0));

    p_countdown_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (std_count != '0 && !std_load) |=>
            (std_count == $past(std_count) || std_count == $past(std_count) - 1'b1));

endmodule

bind pause_tx_gate pqg_checker #(.QUANTA_W(QUANTA_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .cfg_prio_mode   (cfg_prio_mode),
    .cfg_std_xoff_en (cfg_std_xoff_en),
    .evt_addr_hit    (evt_addr_hit),
    .std_load        (std_load),
    .evt_quanta      (evt_quanta),
    .std_count       (std_count),
    .in_frame        (in_frame),
    .cli_ready       (cli_ready),
    .mac_ready       (mac_ready),
    .mac_valid       (mac_valid)
);

// File: tb/pause_tx_gate_test.sv
// Directed bench for pause_tx_gate: one task per scenario.
// Inputs change on the falling edge; outputs are sampled there too.
module pause_tx_gate_test;

    localparam int DW = 256;
    localparam int QW = 16;
    localparam int NC = 8;
    localparam int CPQ = 512 / DW;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          cfg_prio_mode;
    logic [NC-1:0] cfg_rx_pause_en;
    logic          cfg_std_xoff_en;
    logic          evt_valid;
    logic          evt_kind;
    logic          evt_addr_hit;
    logic [QW-1:0] evt_quanta;
    logic [NC-1:0] evt_class_vec;
    logic          cli_valid;
    logic [DW-1:0] cli_data;
    logic          cli_sop;
    logic          cli_eop;
    logic          cli_ready;
    logic          mac_valid;
    logic [DW-1:0] mac_data;
    logic          mac_sop;
    logic          mac_eop;
    logic          mac_ready;
    logic [NC-1:0] class_paused;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    pause_tx_gate #(.DATA_W(DW), .QUANTA_W(QW), .NUM_CLS(NC)) uut (.*);

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    // Drive a one-cycle event; returns at the first sample after it is loaded.
    task automatic pulse(input logic kind, input logic hit, input int q, input logic [NC-1:0] vec);
        evt_valid = 1'b1; evt_kind = kind; evt_addr_hit = hit;
        evt_quanta = QW'(q); evt_class_vec = vec;
        step();
        evt_valid = 1'b0; evt_addr_hit = 1'b1;
    endtask

    // Count consecutive samples with cli_ready low, starting now.
    task automatic hold_len(output int n);
        n = 0;
        while (!cli_ready && n < 400) begin
            n++;
            step();
        end
    endtask

    task automatic std_cfg();
        cfg_prio_mode = 1'b0; cfg_rx_pause_en = '1; cfg_std_xoff_en = 1'b1;
    endtask

    task automatic t_reset();
        check(class_paused == '0, "R10 class_paused", class_paused, 0);
        check(cli_ready == 1'b1, "R10 ready", cli_ready, 1);
    endtask

    task automatic t_length();
        int n;
        std_cfg();
        pulse(1'b0, 1'b1, 3, '0);
        hold_len(n);
        check(n == 3 * CPQ, "R1 hold cycles q=3", n, 3 * CPQ);
        pulse(1'b0, 1'b1, 1, '0);
        hold_len(n);
        check(n == CPQ, "R1 hold cycles q=1", n, CPQ);
    endtask

    task automatic t_gate_blocks();
        std_cfg();
        cli_valid = 1'b1; cli_sop = 1'b1; cli_eop = 1'b1; cli_data = DW'(8'hA5);
        pulse(1'b0, 1'b1, 4, '0);
        check(cli_ready == 1'b0 && mac_valid == 1'b0, "R5 no start while paused",
              {cli_ready, mac_valid}, 0);
        pulse(1'b0, 1'b1, 0, '0);
        check(mac_valid == 1'b1 && mac_data == DW'(8'hA5), "R7 zero quanta release",
              mac_valid, 1);
        cli_valid = 1'b0; cli_sop = 1'b0; cli_eop = 1'b0;
    endtask

    task automatic t_midframe();
        std_cfg();
        cli_valid = 1'b1; cli_sop = 1'b1; cli_eop = 1'b0;
        step();
        cli_sop = 1'b0;
        pulse(1'b0, 1'b1, 5, '0);
        check(cli_ready == 1'b1, "R4 mid beat accepted", cli_ready, 1);
        cli_eop = 1'b1;
        check(cli_ready == 1'b1 && mac_valid == 1'b1, "R4 eop accepted", cli_ready, 1);
        step();
        cli_sop = 1'b1; cli_eop = 1'b1;
        check(cli_ready == 1'b0 && mac_valid == 1'b0, "R4 gate after eop", cli_ready, 0);
        pulse(1'b0, 1'b1, 0, '0);
        cli_valid = 1'b0; cli_sop = 1'b0; cli_eop = 1'b0;
        check(cli_ready == 1'b1, "R7 release after mid-frame pause", cli_ready, 1);
    endtask

    task automatic t_overwrite();
        int n;
        std_cfg();
        pulse(1'b0, 1'b1, 10, '0);
        step();
        pulse(1'b0, 1'b1, 2, '0);
        hold_len(n);
        check(n == 2 * CPQ, "R6 smaller overwrite", n, 2 * CPQ);
        pulse(1'b0, 1'b1, 1, '0);
        pulse(1'b0, 1'b1, 4, '0);
        hold_len(n);
        check(n == 4 * CPQ, "R6 larger overwrite", n, 4 * CPQ);
    endtask

    task automatic t_subrestart();
        int n;
        std_cfg();
        pulse(1'b0, 1'b1, 2, '0);
        step(); step(); step();
        pulse(1'b0, 1'b1, 1, '0);
        hold_len(n);
        check(n == CPQ, "R9 partial quantum restart", n, CPQ);
    endtask

    task automatic t_disabled();
        std_cfg(); cfg_rx_pause_en[0] = 1'b0;
        pulse(1'b0, 1'b1, 5, '0); step();
        check(cli_ready == 1'b1, "R2 rx enable off", cli_ready, 1);
        std_cfg(); cfg_std_xoff_en = 1'b0;
        pulse(1'b0, 1'b1, 5, '0); step();
        check(cli_ready == 1'b1, "R2 xoff enable off", cli_ready, 1);
        std_cfg();
        pulse(1'b0, 1'b0, 5, '0); step();
        check(cli_ready == 1'b1, "R2 address miss", cli_ready, 1);
        pulse(1'b1, 1'b1, 5, 8'hFF); step();
        check(cli_ready == 1'b1 && class_paused == '0, "R11 wrong kind std mode",
              cli_ready, 1);
    endtask

    task automatic t_priority();
        cfg_prio_mode = 1'b1; cfg_rx_pause_en = 8'hFD; cfg_std_xoff_en = 1'b1;
        cli_valid = 1'b1; cli_sop = 1'b1; cli_eop = 1'b1;
        pulse(1'b0, 1'b1, 5, '0);
        check(class_paused == '0 && cli_ready == 1'b1, "R11 wrong kind prio mode",
              class_paused, 0);
        pulse(1'b1, 1'b0, 5, 8'h01);
        check(class_paused == '0, "R3 address miss prio", class_paused, 0);
        pulse(1'b1, 1'b1, 1, 8'h03);
        check(class_paused == 8'h01, "R3 class enable mask", class_paused, 8'h01);
        pulse(1'b1, 1'b1, 3, 8'h04);
        check(class_paused == 8'h05 && cli_ready == 1'b1, "R8 both paused, ready open",
              class_paused, 8'h05);
        step();
        check(class_paused == 8'h04, "R8 class0 expired first", class_paused, 8'h04);
        check(mac_valid == 1'b1, "R8 datapath not gated", mac_valid, 1);
        step(); step(); step(); step();
        check(class_paused == 8'h04, "R8 class2 still running", class_paused, 8'h04);
        step();
        check(class_paused == 8'h00, "R8 class2 expired", class_paused, 0);
        pulse(1'b1, 1'b1, 9, 8'h80);
        pulse(1'b1, 1'b1, 0, 8'h80);
        check(class_paused == 8'h00, "R7 zero quanta class release", class_paused, 0);
        cli_valid = 1'b0; cli_sop = 1'b0; cli_eop = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++; n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        rst_n = 1'b0; cfg_prio_mode = 1'b0; cfg_rx_pause_en = '1; cfg_std_xoff_en = 1'b1;
        evt_valid = 1'b0; evt_kind = 1'b0; evt_addr_hit = 1'b1; evt_quanta = '0;
        evt_class_vec = '0; cli_valid = 1'b0; cli_data = '0; cli_sop = 1'b0;
        cli_eop = 1'b0; mac_ready = 1'b1;
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_length();
        t_gate_blocks();
        t_midframe();
        t_overwrite();
        t_subrestart();
        t_disabled();
        t_priority();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule